// File: doc/BRIEF.md
# Tag-Aware Virtual Address Checker

This unit sits beside the address path of a load/store pipeline. For every 64-bit virtual address it finds the highest address bit that counts. That bit depends on the privilege level (0 to 3), on whether the current level runs in 32-bit mode, and on a set of per-level switches that tell the hardware to ignore the top byte. When the top byte is ignored, software is free to keep a tag there. Such a tag must not cause a range fault, and it must not stop an invalidate-by-address compare from matching.

From that top-bit index, the unit raises a range-fault flag when the address lies outside the configured virtual-address size. It also raises a match flag when the address hits a TLB-invalidate-by-address target at page granularity. The same fault flag serves both the translation-on case and the translation-off case, so the tag-ignore switches apply whether or not translation is enabled. A fault address register captures the raw address, tag included, on a one-cycle strobe.

All results are registered and appear one clock after the inputs.

Top module: `tagchk_top`

## Requirements
- R1: When the current level runs in 32-bit mode, `topBit` is 31. The exception is level 0 in 32-bit mode while level 1 is not in 32-bit mode (see R2).
- R2: At level 0 in 32-bit mode with level 1 in 64-bit mode, the 64-bit rules apply to the address with bits 63:32 replaced by zero, so the lower-half switch always governs.
- R3: At levels 0 and 1 in 64-bit rules, address bit 55 picks the switch: bit 55 = 1 uses `tagIgnHi01` and bit 55 = 0 uses `tagIgnLo01`.
- R4: At level 2 `tagIgnL2` is the switch, and at level 3 `tagIgnL3` is the switch. Under 64-bit rules, `topBit` is 55 when the selected switch is 1 and 63 when it is 0.
- R5: Every address bit from VA_BITS up to `topBit` must be 1 in the upper half (levels 0/1 with bit 55 = 1) and 0 in every other case. Any other value sets `rangeFault`. Bits above `topBit`, such as a tag in bits 63:56, are never checked.
- R6: `invMatch` is 1 exactly when the address and `invTarget` agree in every bit from PAGE_BITS up to `topBit`. Lower bits and bits above `topBit` are ignored.
- R7: `faultAddr` loads the unmodified `vaddr`, tag bits included, in the cycle after `captureStb` is 1, and keeps its value while `captureStb` is 0.
- R8: `topBit`, `rangeFault` and `invMatch` reflect the inputs of the previous clock. While `rstN` is low they read 63, 0 and 0, and `faultAddr` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vaddr | input | 64 | Virtual address under check |
| privLevel | input | 2 | Current privilege level 0..3 |
| curIs32 | input | 1 | Current level runs in 32-bit mode |
| lvl1Is32 | input | 1 | Level 1 runs in 32-bit mode |
| tagIgnLo01 | input | 1 | Ignore top byte, levels 0/1, lower half |
| tagIgnHi01 | input | 1 | Ignore top byte, levels 0/1, upper half |
| tagIgnL2 | input | 1 | Ignore top byte, level 2 |
| tagIgnL3 | input | 1 | Ignore top byte, level 3 |
| invTarget | input | 64 | Invalidate-by-address target |
| captureStb | input | 1 | Load fault address register |
| topBit | output | 6 | Index of the top meaningful address bit |
| rangeFault | output | 1 | Address out of range |
| invMatch | output | 1 | Address matches invalidate target |
| faultAddr | output | 64 | Captured fault address |

## Verification
The bench builds the unit with VA_BITS = 44 and PAGE_BITS = 14 instead of the defaults 48 and 12. The narrower address size leaves a wide band, bits 44..55, that must hold all zeros or all ones below the tag byte, so faults caused only by that band can be separated from faults caused only by the tag byte. The larger page size places the compare boundary at bit 14, which lets one vector flip bit 13 (ignored) and another flip bit 14 (decisive).

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;
  localparam int ADDR_W     = 64;
  localparam int HALF_BIT   = 55;
  localparam int NARROW_TOP = 31;
  localparam int IDX_W      = $clog2(ADDR_W);

  typedef logic [IDX_W-1:0] bitIdx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic narrow;     // 32-bit regime
    logic zeroExt;    // upper word forced to zero
    logic useTag;     // top byte ignored
    logic upperHalf;  // bits above VA size must be ones
    logic capture;    // load fault address
  } tagStrobes_t;
endpackage

// File: rtl/tagchk_ctrl.sv
module tagchk_ctrl
  import tagchk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        vaBit55,
  input  logic [1:0]  privLevel,
  input  logic        curIs32,
  input  logic        lvl1Is32,
  input  logic        tagIgnLo01,
  input  logic        tagIgnHi01,
  input  logic        tagIgnL2,
  input  logic        tagIgnL3,
  input  logic        captureStb,
  output tagStrobes_t strb
);
  logic wideRegime;
  logic zeroExt;
  logic effBit55;
  logic selEnable;

  always_comb begin
    zeroExt    = curIs32 && (privLevel == 2'd0) && !lvl1Is32;
    wideRegime = !curIs32 || zeroExt;
    effBit55   = zeroExt ? 1'b0 : vaBit55;
    unique case (privLevel)
      2'd0, 2'd1: selEnable = effBit55 ? tagIgnHi01 : tagIgnLo01;
      2'd2:       selEnable = tagIgnL2;
      default:    selEnable = tagIgnL3;
    endcase
    strb.narrow    = !wideRegime;
    strb.zeroExt   = zeroExt;
    strb.useTag    = wideRegime && selEnable;
    strb.upperHalf = wideRegime && !privLevel[1] && effBit55;
    strb.capture   = captureStb;
  end

  // R1: plain 32-bit execution always selects the narrow regime
  a_r1_narrow: assert property (@(posedge clk) disable iff (!rstN)
    (curIs32 && (privLevel != 2'd0 || lvl1Is32)) |-> strb.narrow);

  // R3: upper-half switch governs when bit 55 is set at levels 0/1
  a_r3_upper_sel: assert property (@(posedge clk) disable iff (!rstN)
    (!curIs32 && privLevel < 2'd2 && vaBit55)
      |-> (strb.useTag == tagIgnHi01) && strb.upperHalf);

  // R4: level 3 follows its own switch
  a_r4_level3: assert property (@(posedge clk) disable iff (!rstN)
    (!curIs32 && privLevel == 2'd3) |-> (strb.useTag == tagIgnL3) && !strb.upperHalf);
endmodule

// File: rtl/tagchk_dp.sv
module tagchk_dp
  import tagchk_pkg::*;
#(
  parameter int VA_BITS   = 48,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  tagStrobes_t       strb,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] invTarget,
  output bitIdx_t           topBit,
  output logic              rangeFault,
  output logic              invMatch,
  output logic [ADDR_W-1:0] faultAddr
);
  logic [ADDR_W-1:0] effVa;
  logic [ADDR_W-1:0] rangeMask;
  logic [ADDR_W-1:0] cmpMask;
  logic [ADDR_W-1:0] wantBits;
  bitIdx_t           topComb;
  logic              faultComb;
  logic              matchComb;

  always_comb begin
    effVa = strb.zeroExt ? {32'b0, vaddr[31:0]} : vaddr;
    if (strb.narrow)      topComb = bitIdx_t'(NARROW_TOP);
    else if (strb.useTag) topComb = bitIdx_t'(HALF_BIT);
    else                  topComb = bitIdx_t'(ADDR_W - 1);
  end

  generate
    for (genvar g = 0; g < ADDR_W; g++) begin : gMask
      assign rangeMask[g] = (g >= VA_BITS)   && (g <= int'(topComb));
      assign cmpMask[g]   = (g >= PAGE_BITS) && (g <= int'(topComb));
    end
  endgenerate

  always_comb begin
    wantBits  = {ADDR_W{strb.upperHalf}};
    faultComb = |((effVa ^ wantBits) & rangeMask);
    matchComb = ~|((effVa ^ invTarget) & cmpMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topBit     <= bitIdx_t'(ADDR_W - 1);
      rangeFault <= 1'b0;
      invMatch   <= 1'b0;
      faultAddr  <= '0;
    end else begin
      topBit     <= topComb;
      rangeFault <= faultComb;
      invMatch   <= matchComb;
      if (strb.capture) faultAddr <= vaddr;
    end
  end

  // R8: registered index only ever takes one of three legal values
  a_r8_top_legal: assert property (@(posedge clk) disable iff (!rstN)
    topBit == bitIdx_t'(NARROW_TOP) || topBit == bitIdx_t'(HALF_BIT)
      || topBit == bitIdx_t'(ADDR_W - 1));

  // R7: capture loads the raw address including its tag
  a_r7_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> faultAddr == $past(vaddr));

  // R7: no capture, no change
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(faultAddr));
endmodule

// File: rtl/tagchk_top.sv
module tagchk_top
  import tagchk_pkg::*;
#(
  parameter int VA_BITS   = 48,
  parameter int PAGE_BITS = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] vaddr,
  input  logic [1:0]  privLevel,
  input  logic        curIs32,
  input  logic        lvl1Is32,
  input  logic        tagIgnLo01,
  input  logic        tagIgnHi01,
  input  logic        tagIgnL2,
  input  logic        tagIgnL3,
  input  logic [63:0] invTarget,
  input  logic        captureStb,
  output logic [5:0]  topBit,
  output logic        rangeFault,
  output logic        invMatch,
  output logic [63:0] faultAddr
);
  tagStrobes_t strb;

  tagchk_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .vaBit55    (vaddr[HALF_BIT]),
    .privLevel  (privLevel),
    .curIs32    (curIs32),
    .lvl1Is32   (lvl1Is32),
    .tagIgnLo01 (tagIgnLo01),
    .tagIgnHi01 (tagIgnHi01),
    .tagIgnL2   (tagIgnL2),
    .tagIgnL3   (tagIgnL3),
    .captureStb (captureStb),
    .strb       (strb)
  );

  tagchk_dp #(.VA_BITS(VA_BITS), .PAGE_BITS(PAGE_BITS)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .vaddr      (vaddr),
    .invTarget  (invTarget),
    .topBit     (topBit),
    .rangeFault (rangeFault),
    .invMatch   (invMatch),
    .faultAddr  (faultAddr)
  );
endmodule

// File: tb/tagchk_top_test.sv
`timescale 1ns/1ps
module tagchk_top_test;
  localparam int VA_B = 44;
  localparam int PG_B = 14;

  typedef struct {
    logic [5:0]  top;
    logic        flt;
    logic        mt;
    logic [63:0] fa;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] vaddr = '0;
  logic [1:0]  privLevel = '0;
  logic        curIs32 = 1'b0, lvl1Is32 = 1'b0;
  logic        tagIgnLo01 = 1'b0, tagIgnHi01 = 1'b0, tagIgnL2 = 1'b0, tagIgnL3 = 1'b0;
  logic [63:0] invTarget = '0;
  logic        captureStb = 1'b0;
  logic [5:0]  topBit;
  logic        rangeFault, invMatch;
  logic [63:0] faultAddr;

  int nChecks = 0;
  int nFails = 0;
  item_t expQ[$];
  logic [63:0] expFault = '0;

  always #4 clk = ~clk;

  tagchk_top #(.VA_BITS(VA_B), .PAGE_BITS(PG_B)) uut (
    .clk(clk), .rstN(rstN), .vaddr(vaddr), .privLevel(privLevel),
    .curIs32(curIs32), .lvl1Is32(lvl1Is32), .tagIgnLo01(tagIgnLo01),
    .tagIgnHi01(tagIgnHi01), .tagIgnL2(tagIgnL2), .tagIgnL3(tagIgnL3),
    .invTarget(invTarget), .captureStb(captureStb), .topBit(topBit),
    .rangeFault(rangeFault), .invMatch(invMatch), .faultAddr(faultAddr)
  );

  function automatic void finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endfunction

  // driver: apply one vector, push expectation from the requirements
  task automatic drive(input logic [63:0] va, input logic [1:0] lv, input logic c32,
                       input logic l132, input logic lo, input logic hi, input logic e2,
                       input logic e3, input logic [63:0] tg, input logic cap, input string req);
    item_t it;
    logic [63:0] ea;
    logic wide, sel, want;
    int top;
    @(negedge clk);
    vaddr = va; privLevel = lv; curIs32 = c32; lvl1Is32 = l132;
    tagIgnLo01 = lo; tagIgnHi01 = hi; tagIgnL2 = e2; tagIgnL3 = e3;
    invTarget = tg; captureStb = cap;
    wide = !c32 || (lv == 2'd0 && !l132);                      // R1, R2
    ea = (c32 && wide) ? {32'b0, va[31:0]} : va;               // R2
    if (lv < 2) sel = ea[55] ? hi : lo;                        // R3
    else sel = (lv == 2) ? e2 : e3;                            // R4
    top = !wide ? 31 : (sel ? 55 : 63);
    want = wide && lv < 2 && ea[55];                           // R5
    it.flt = 1'b0;
    for (int i = VA_B; i < 64; i++) if (i <= top && ea[i] != want) it.flt = 1'b1;
    it.mt = 1'b1;                                              // R6
    for (int i = PG_B; i < 64; i++) if (i <= top && ea[i] != tg[i]) it.mt = 1'b0;
    if (cap) expFault = va;                                    // R7
    it.top = 6'(top); it.fa = expFault; it.req = req;
    expQ.push_back(it);
  endtask

  // monitor: compare one cycle after each applied vector
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        nChecks++;
        if (topBit !== it.top || rangeFault !== it.flt || invMatch !== it.mt ||
            faultAddr !== it.fa) begin
          nFails++;
          $display("FAIL %s: got top=%0d flt=%b mt=%b fa=%h exp top=%0d flt=%b mt=%b fa=%h",
                   it.req, topBit, rangeFault, invMatch, faultAddr,
                   it.top, it.flt, it.mt, it.fa);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        nFails++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset values
    nChecks++;
    if (topBit !== 6'd63 || rangeFault !== 1'b0 || invMatch !== 1'b0 || faultAddr !== 64'd0) begin
      nFails++;
      $display("FAIL R8 reset: got top=%0d flt=%b mt=%b fa=%h exp 63 0 0 0",
               topBit, rangeFault, invMatch, faultAddr);
    end
    rstN = 1'b1;
    // R1 narrow regime at level 1, junk in upper word
    drive(64'hFFFF_0000_1234_5678, 2'd1, 1, 0, 1, 1, 0, 0, 64'h0000_0000_1234_4000, 0, "R1");
    drive(64'h0000_0000_8000_4000, 2'd2, 1, 0, 0, 0, 1, 0, 64'hAAAA_0000_8000_4000, 0, "R1");
    // R2 level 0 zero-extended under wide level 1
    drive(64'hAB80_0000_8000_0000, 2'd0, 1, 0, 0, 1, 0, 0, 64'h0, 0, "R2");
    drive(64'hAB80_0000_8000_0000, 2'd0, 1, 1, 0, 1, 0, 0, 64'h0, 0, "R2");
    // R3 half selection
    drive(64'h5AFF_FFFF_FFFF_0000, 2'd1, 0, 0, 0, 1, 0, 0, 64'h0, 0, "R3");
    drive(64'h5AFF_FFFF_FFFF_0000, 2'd1, 0, 0, 1, 0, 0, 0, 64'h0, 0, "R3");
    drive(64'h7700_0000_0001_0000, 2'd0, 0, 0, 1, 0, 0, 0, 64'h0, 0, "R3");
    drive(64'h7700_0000_0001_0000, 2'd0, 0, 0, 0, 1, 0, 0, 64'h0, 0, "R3");
    // R4 levels 2 and 3
    drive(64'hFF00_0000_0000_1000, 2'd2, 0, 0, 0, 0, 1, 0, 64'h0, 0, "R4");
    drive(64'hFF00_0000_0000_1000, 2'd2, 0, 0, 0, 0, 0, 1, 64'h0, 0, "R4");
    drive(64'h3300_0000_0000_1000, 2'd3, 0, 0, 1, 1, 0, 1, 64'h0, 0, "R4");
    // R5 band below the tag byte
    drive(64'h0000_1000_0000_0000, 2'd2, 0, 0, 0, 0, 1, 0, 64'h0, 0, "R5");
    drive(64'h0080_0000_0000_0000, 2'd3, 0, 0, 0, 0, 0, 1, 64'h0, 0, "R5");
    drive(64'h12FB_FFFF_FFFF_0000, 2'd1, 0, 0, 0, 1, 0, 0, 64'h0, 0, "R5");
    drive(64'hFFFF_F000_0000_0000, 2'd0, 0, 0, 0, 0, 0, 0, 64'h0, 0, "R5");
    // R6 invalidate compare
    drive(64'h1100_00AB_CDEF_8000, 2'd1, 0, 0, 1, 0, 0, 0, 64'h2200_00AB_CDEF_8000, 0, "R6");
    drive(64'h1100_00AB_CDEF_8000, 2'd1, 0, 0, 0, 0, 0, 0, 64'h2200_00AB_CDEF_8000, 0, "R6");
    drive(64'h0000_00AB_CDEF_8000, 2'd2, 0, 0, 0, 0, 0, 0, 64'h0000_00AB_CDEF_A000, 0, "R6");
    drive(64'h0000_00AB_CDEF_8000, 2'd2, 0, 0, 0, 0, 0, 0, 64'h0000_00AB_CDEF_C000, 0, "R6");
    // R7 capture keeps the tag, then holds
    drive(64'hC5FF_FFFF_1234_5678, 2'd1, 0, 0, 0, 1, 0, 0, 64'h0, 1, "R7");
    drive(64'h0000_0000_0000_0040, 2'd2, 0, 0, 0, 0, 0, 0, 64'h0, 0, "R7");
    drive(64'h9900_0000_0000_0080, 2'd0, 0, 0, 1, 0, 0, 0, 64'h0, 0, "R7");
    drive(64'h9900_0000_0000_0080, 2'd0, 0, 0, 1, 0, 0, 0, 64'h0, 1, "R7");
    @(negedge clk);
    captureStb = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule